// File: doc/BRIEF.md
# SAR Conversion Controller

This block is the digital sequencer of a successive-approximation analog-to-digital converter. It watches three asynchronous control lines (an active-high enable, an active-low select and a read/convert line that requests a conversion when low). It brings them into the system clock domain and starts a conversion on the rising edge of their combined condition. Whichever line arrives last triggers the start, and all three may move together.

At the start the controller captures a length-select line that picks a full 12-bit cycle or a short 8-bit cycle. It clears its approximation register, raises a busy flag and tries the bits one per clock, most significant first, against a single comparator input. While it does so it drives the current trial code towards the DAC. At the end it drops busy, pulses an end-of-conversion strobe and loads the result register, which the separate output-gating block reads.

A start that arrives while busy does not restart the sequence. It does, however, capture the length select again, so the cycle already in progress can be shortened. A short cycle leaves a fixed pattern in the untried low bits of the result.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A conversion starts when `en_i`=1, `sel_n_i`=0 and `rd_cnv_i`=0 all hold, whichever becomes true last, including all three changing together. Busy rises on the third clock edge after the final input change, counting the two synchronizer stages and the start detector.
- R2: No conversion starts while any one of the three start conditions is missing. Busy stays low and the result register is unchanged.
- R3: The approximation register is cleared at start. `trial_o` is zero in the first busy cycle, which is the sample cycle.
- R4: Bits are tried most significant first. In the second busy cycle `trial_o` is 0x800 in the default 12-bit width. A trial bit is kept when `cmp_lt_i`=1 (DAC sum below input) and cleared when it is 0.
- R5: A 12-bit conversion keeps `busy_o` high for exactly 14 clock cycles: one sample cycle, 12 trials and one end cycle. `eoc_o` is a one-cycle pulse in the cycle in which busy has just fallen.
- R6: `short_i` is captured at start. A value of 1 selects an 8-bit cycle that ends after the bit-4 trial, giving 10 busy cycles. A value of 0 selects the 12-bit cycle.
- R7: A start condition seen while busy neither restarts nor resets the conversion in progress.
- R8: A start condition seen while busy captures `short_i` again. If it turns to 1 before the bit-4 trial, the running cycle ends as an 8-bit cycle.
- R9: After an 8-bit cycle the result's bits [3:0] read 4'b1000 and bits [11:4] hold the converted code.
- R10: After reset, `busy_o`, `eoc_o`, `trial_o` and `result_o` are zero. `result_o` holds its value until the next end of conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable, active high, asynchronous |
| sel_n_i | input | 1 | Select, active low, asynchronous |
| rd_cnv_i | input | 1 | Low requests conversion, high requests read |
| short_i | input | 1 | Length select captured at start: 1 = 8-bit, 0 = 12-bit |
| cmp_lt_i | input | 1 | Comparator: 1 when DAC trial sum is below the input |
| busy_o | output | 1 | High while a conversion is in progress |
| trial_o | output | RES_W | Current DAC trial code |
| result_o | output | RES_W | Final conversion result |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
A wrong trial pointer or approximation register shows at the ports within one or two clocks of the start. It appears either as a trial code other than zero in the sample cycle or other than the MSB alone in the first trial cycle, or later as a result that differs from the bench's analog value. A wrong length latch, or a restart inside a busy window, shows when busy falls, because the busy window is then not exactly 10 or 14 cycles long. A wrong residual pattern shows in the low nibble of the very next result.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SAMPLE = 2'd1,
      ST_TRIAL  = 2'd2,
      ST_EOC    = 2'd3
   } sar_state_e;
endpackage

// File: rtl/sar_in_sync.sv
module sar_in_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe <= '0;
            end else begin
               pipe[0] <= d_i;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q_o = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sar_start_det.sv
module sar_start_det (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic sel_n_i,
   input  logic rd_cnv_i,
   output logic start_o
);
   logic cond, cond_q;

   assign cond = en_i & ~sel_n_i & ~rd_cnv_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= 1'b0;
      else        cond_q <= cond;
   end

   assign start_o = cond & ~cond_q;

   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o); // R1
endmodule

// File: rtl/sar_seq.sv
module sar_seq
   import sar_pkg::*;
#(
   parameter int RES_W   = 12,
   parameter int SHORT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             short_i,
   input  logic             cmp_lt_i,
   output logic             busy_o,
   output logic [RES_W-1:0] trial_o,
   output logic [RES_W-1:0] result_o,
   output logic             eoc_o
);
   localparam int LOW_W = RES_W - SHORT_W;
   localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};
   localparam logic [RES_W-1:0] RESID   = RES_W'(1) << (LOW_W - 1);

   sar_state_e       st;
   logic [RES_W-1:0] sar;
   logic [RES_W-1:0] ptr;
   logic             short_q;
   logic             last_trial;

   assign last_trial = ptr[0] | (short_q & ptr[LOW_W]);
   assign trial_o    = (st == ST_TRIAL) ? (sar | ptr) : sar;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         sar      <= '0;
         ptr      <= '0;
         short_q  <= 1'b0;
         busy_o   <= 1'b0;
         eoc_o    <= 1'b0;
         result_o <= '0;
      end else begin
         eoc_o <= 1'b0;
         if (start_i) short_q <= short_i;
         case (st)
            ST_IDLE: begin
               if (start_i) begin
                  st     <= ST_SAMPLE;
                  sar    <= '0;
                  ptr    <= '0;
                  busy_o <= 1'b1;
               end
            end
            ST_SAMPLE: begin
               ptr <= MSB_ONE;
               st  <= ST_TRIAL;
            end
            ST_TRIAL: begin
               if (cmp_lt_i) sar <= sar | ptr;
               ptr <= ptr >> 1;
               if (last_trial) st <= ST_EOC;
            end
            ST_EOC: begin
               result_o <= short_q ? (sar | RESID) : sar;
               busy_o   <= 1'b0;
               eoc_o    <= 1'b1;
               ptr      <= '0;
               st       <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_EOC_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_o |-> !busy_o); // R5
   AST_BUSY_FALL_EOC: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> eoc_o); // R5
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && st != ST_IDLE) |=> st != ST_SAMPLE); // R7
   AST_SAMPLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SAMPLE) |-> (sar == '0)); // R3
   AST_PTR_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ptr)); // R4
   AST_TRIAL_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TRIAL) |-> ($countones(ptr) == 1)); // R4
   AST_SHORT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_EOC && short_q) |=> (result_o[LOW_W-1:0] == RESID[LOW_W-1:0])); // R9
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
   parameter int RES_W       = 12,
   parameter int SHORT_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             sel_n_i,
   input  logic             rd_cnv_i,
   input  logic             short_i,
   input  logic             cmp_lt_i,
   output logic             busy_o,
   output logic [RES_W-1:0] trial_o,
   output logic [RES_W-1:0] result_o,
   output logic             eoc_o
);
   localparam int N_CTRL = 4;

   generate
      if (SHORT_W < 1 || SHORT_W >= RES_W) begin : g_bad_len
         $error("SHORT_W must be between 1 and RES_W-1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [N_CTRL-1:0] ctrl_raw, ctrl_s;
   logic              start;

   assign ctrl_raw = {short_i, rd_cnv_i, sel_n_i, en_i};

   sar_in_sync #(.W(N_CTRL), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ctrl_raw),
      .q_o   (ctrl_s)
   );

   sar_start_det u_start (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (ctrl_s[0]),
      .sel_n_i  (ctrl_s[1]),
      .rd_cnv_i (ctrl_s[2]),
      .start_o  (start)
   );

   sar_seq #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .short_i  (ctrl_s[3]),
      .cmp_lt_i (cmp_lt_i),
      .busy_o   (busy_o),
      .trial_o  (trial_o),
      .result_o (result_o),
      .eoc_o    (eoc_o)
   );

   AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start)); // R1
endmodule

// File: tb/tb_sar_conv_ctrl.sv
module tb_sar_conv_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0, sel_n = 1'b1, rd_cnv = 1'b1, shrt = 1'b0;
   logic        cmp_lt;
   logic        busy, eoc;
   logic [11:0] trial, result;
   logic [11:0] vin = 12'h000;

   int checks = 0, fails = 0;
   int busy_cnt = 0, busy_total = 0, eoc_total = 0;

   typedef struct { logic [11:0] res; int len; } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   assign cmp_lt = (trial <= vin);

   sar_conv_ctrl dut (
      .clk(clk), .rst_n(rst_n), .en_i(en), .sel_n_i(sel_n), .rd_cnv_i(rd_cnv),
      .short_i(shrt), .cmp_lt_i(cmp_lt), .busy_o(busy), .trial_o(trial),
      .result_o(result), .eoc_o(eoc)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // monitor: compares busy window, early trial codes and result against scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (busy) begin
               if (busy_cnt == 0) chk(trial == 12'h000, "R3 trial zero in sample cycle", trial, 0);
               if (busy_cnt == 1) chk(trial == 12'h800, "R4 first trial is MSB", trial, 12'h800);
               busy_cnt++;
               busy_total++;
            end
            if (eoc) begin
               eoc_total++;
               chk(!busy, "R5 eoc with busy low", busy, 0);
               if (sb.size() == 0) begin
                  chk(1'b0, "R7 unexpected conversion end", result, 0);
               end else begin
                  exp_t e;
                  e = sb.pop_front();
                  chk(result == e.res, "R4 R9 result", result, e.res);
                  if (e.len == 14) chk(busy_cnt == 14, "R5 R7 busy window 12-bit", busy_cnt, 14);
                  else             chk(busy_cnt == e.len, "R6 R8 busy window 8-bit", busy_cnt, e.len);
               end
               busy_cnt = 0;
            end
         end
      end
   end

   task automatic idle_ctrl();
      @(negedge clk);
      en = 1'b0; sel_n = 1'b1; rd_cnv = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_conv();
      @(negedge busy);
      repeat (3) @(negedge clk);
      idle_ctrl();
   endtask

   // kind: 0 = convert line last, 1 = select last, 2 = enable last, 3 = all together
   task automatic conv(input int kind, input bit sh, input logic [11:0] v,
                       input logic [11:0] er, input int el);
      exp_t e;
      e.res = er; e.len = el;
      @(negedge clk);
      vin = v; shrt = sh;
      sb.push_back(e);
      case (kind)
         0: begin en = 1; sel_n = 0; repeat (3) @(negedge clk); rd_cnv = 0; end // R1
         1: begin en = 1; rd_cnv = 0; repeat (3) @(negedge clk); sel_n = 0; end // R1
         2: begin sel_n = 0; rd_cnv = 0; repeat (3) @(negedge clk); en = 1; end // R1
         default: begin en = 1; sel_n = 0; rd_cnv = 0; end                   // R1
      endcase
      // R1: busy rises at the third edge after the last change
      @(negedge clk); @(negedge clk);
      chk(!busy, "R1 busy still low after two edges", busy, 0);
      @(negedge clk);
      chk(busy, "R1 busy high after third edge", busy, 1);
      finish_conv();
   endtask

   // start again while busy; sh_new is the length select applied with it
   task automatic busy_restart(input bit sh_new, input logic [11:0] v,
                               input logic [11:0] er, input int el);
      exp_t e;
      e.res = er; e.len = el;
      @(negedge clk);
      vin = v; shrt = 1'b0;
      sb.push_back(e);
      en = 1; sel_n = 0; rd_cnv = 0;
      @(posedge busy);
      @(negedge clk);
      rd_cnv = 1; shrt = sh_new;
      repeat (3) @(negedge clk);
      rd_cnv = 0;
      finish_conv();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 0,    "R10 reset busy",   busy, 0);
      chk(eoc == 0,     "R10 reset eoc",    eoc, 0);
      chk(trial == 0,   "R10 reset trial",  trial, 0);
      chk(result == 0,  "R10 reset result", result, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      conv(0, 1'b0, 12'hABC, 12'hABC, 14);
      conv(1, 1'b0, 12'h000, 12'h000, 14);
      conv(2, 1'b0, 12'hFFF, 12'hFFF, 14);
      conv(3, 1'b1, 12'h5A7, 12'h5A8, 10);   // R6 R9
      conv(0, 1'b1, 12'hFFF, 12'hFF8, 10);   // R9
      conv(1, 1'b1, 12'h000, 12'h008, 10);   // R9
      conv(3, 1'b0, 12'h801, 12'h801, 14);

      // R2: each start condition missing in turn
      begin
         int b0;
         b0 = busy_total;
         @(negedge clk); en = 1; sel_n = 0; rd_cnv = 1; repeat (10) @(negedge clk);
         idle_ctrl();
         en = 0; sel_n = 0; rd_cnv = 0; repeat (10) @(negedge clk);
         idle_ctrl();
         en = 1; sel_n = 1; rd_cnv = 0; repeat (10) @(negedge clk);
         idle_ctrl();
         chk(busy_total == b0, "R2 no busy without full start", busy_total - b0, 0);
         chk(result == 12'h801, "R2 result unchanged", result, 12'h801);
      end

      busy_restart(1'b1, 12'h3C5, 12'h3C8, 10);  // R8
      busy_restart(1'b0, 12'h7E1, 12'h7E1, 14);  // R7

      begin
         int e0;
         e0 = eoc_total;
         repeat (20) @(negedge clk);
         chk(result == 12'h7E1, "R10 result holds", result, 12'h7E1);
         chk(eoc_total == e0, "R7 no extra conversion", eoc_total - e0, 0);
      end
      chk(sb.size() == 0, "R5 all conversions completed", sb.size(), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule